// File: doc/BRIEF.md
# SDRAM Bank State and Auto-Precharge Tracker

This block watches the command pins of a synchronous DRAM interface. It keeps a record of which of the four banks are open and which row each open bank holds. It samples a command on each rising clock edge. A command counts only if chip select is low and clock enable was high at the edge before. The block decodes four commands: activate, read, write and single-bank precharge. Any other code passes through without effect.

A read or write starts a burst of `BURST_LEN` beats. Address bit `AP_BIT` on that command sets the auto-precharge choice for the bank it targets. If the bit is set, the block keeps a pending close for that bank. It clears the bank's open flag on the edge that follows the last beat. While clock enable is low, the burst countdown is frozen. A one-cycle error flag reports commands that conflict with the tracked bank state; such commands change nothing.

A controller or a protocol monitor can use the flags to gate its own commands. It can also compare them against its intended schedule.

Top module: `sdram_bank_tracker`

## Requirements
- R1: While reset is high and after its release, every bank reads closed, every open-row register reads zero and `cmd_err` is low.
- R2: A command takes effect at an edge only if `cs_n` is low at that edge and `cke` was high at the previous edge. With `cs_n` high the edge changes no bank state and raises no error.
- R3: If `cke` is low at edge e, edge e+1 accepts no command and raises no error. The burst countdown does not advance at edge e+1.
- R4: An activate ({ras_n,cas_n,we_n}=011) to a closed bank sets that bank's active flag. It also stores `addr` as its open row. Both are visible after the edge. The bank is selected by `ba`, with 00, 01, 10 and 11 naming banks 0 to 3.
- R5: An activate to an open bank raises `cmd_err` and leaves the bank's flag and row unchanged.
- R6: A read (101) or write (100) to a closed bank raises `cmd_err` and starts no burst.
- R7: A read or write with `addr[AP_BIT]`=0 leaves its bank open after the burst.
- R8: A read or write with `addr[AP_BIT]`=1 keeps its bank open through `BURST_LEN` unsuspended edges, counting the command edge. The bank closes at the next unsuspended edge.
- R9: A precharge (010) closes the bank chosen by `ba` and cancels its pending auto-precharge. A precharge to a closed bank changes nothing and raises no error.
- R10: A read or write that arrives while an auto-precharge burst is still counting down raises `cmd_err` and is dropped. A read or write during a burst without auto-precharge is accepted and restarts the countdown.
- R11: The codes 111, 000, 001 and 110 change no bank state and raise no error.
- R12: `cmd_err` is high for exactly the one cycle that follows an edge at which an erroneous qualified command was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| cke | input | 1 | Clock enable; gates the following edge |
| ras_n | input | 1 | Row strobe command bit |
| cas_n | input | 1 | Column strobe command bit |
| we_n | input | 1 | Write enable command bit |
| ba | input | 2 | Bank select |
| addr | input | ROW_W | Row address on activate; bit AP_BIT selects auto-precharge on read/write |
| bank_active | output | 4 | Per-bank open flag |
| open_row | output | 4×ROW_W | Row held by each bank, last activated value |
| cmd_err | output | 1 | One-cycle flag for a conflicting command |

## Verification
A wrong active flag or pending-close bit shows up within one edge. It appears as a bank flag that differs from the reference, or as a `cmd_err` pulse that is missing or extra on the next activate, read or write to that bank. An off-by-one in the burst countdown moves the auto-close by a cycle. The per-cycle comparison catches that on the exact edge. A suspension or chip-select leak appears as a state change on the cycle after the ignored edge.

// File: rtl/sdram_bank_pkg.sv
package sdram_bank_pkg;

    localparam int NUM_BANKS = 4;
    localparam int BA_W      = $clog2(NUM_BANKS);

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_OTHER
    } cmd_e;

    typedef struct packed {
        cmd_e            kind;
        logic [BA_W-1:0] bank;
        logic            ap;
    } cmd_t;

    function automatic cmd_e decode_cmd(input logic r_n, input logic c_n, input logic w_n);
        case ({r_n, c_n, w_n})
            3'b111:  return CMD_NOP;
            3'b011:  return CMD_ACT;
            3'b101:  return CMD_RD;
            3'b100:  return CMD_WR;
            3'b010:  return CMD_PRE;
            default: return CMD_OTHER;
        endcase
    endfunction

    function automatic logic is_rw(input cmd_e k);
        return (k == CMD_RD) || (k == CMD_WR);
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_bank_pkg::*;
#(
    parameter int ROW_W  = 11,
    parameter int AP_BIT = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             cke,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [BA_W-1:0]  ba,
    input  logic [ROW_W-1:0] addr,
    output cmd_t             cmd,
    output logic             run
);

    logic cke_q;

    always_ff @(posedge clk) begin
        if (rst) cke_q <= 1'b0;
        else     cke_q <= cke;
    end

    assign run = cke_q;

    always_comb begin
        cmd.kind = (cke_q && !cs_n) ? decode_cmd(ras_n, cas_n, we_n) : CMD_NOP;
        cmd.bank = ba;
        cmd.ap   = addr[AP_BIT];
    end

endmodule

// File: rtl/sdram_burst_sched.sv
module sdram_burst_sched
    import sdram_bank_pkg::*;
#(
    parameter int BURST_LEN = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            start,
    input  logic [BA_W-1:0] start_bank,
    output logic            live,
    output logic [BA_W-1:0] cur_bank,
    output logic            last_edge
);

    localparam int CNT_W = $clog2(BURST_LEN + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain   <= '0;
            cur_bank <= '0;
        end else if (run) begin
            if (start) begin
                remain   <= CNT_W'(BURST_LEN);
                cur_bank <= start_bank;
            end else if (remain != '0) begin
                remain <= remain - 1'b1;
            end
        end
    end

    assign live      = (remain != '0);
    assign last_edge = run && (remain == CNT_W'(1));

endmodule

// File: rtl/sdram_bank_slice.sv
module sdram_bank_slice #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_set,
    input  logic [ROW_W-1:0] row_in,
    input  logic             pre_clr,
    input  logic             ap_set,
    input  logic             auto_end,
    output logic             active,
    output logic [ROW_W-1:0] row,
    output logic             pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            row    <= '0;
            pend   <= 1'b0;
        end else begin
            if (act_set) begin
                active <= 1'b1;
                row    <= row_in;
            end
            if (pre_clr || (auto_end && pend)) begin
                active <= 1'b0;
                pend   <= 1'b0;
            end else if (ap_set) begin
                pend <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_bank_pkg::*;
#(
    parameter int ROW_W     = 11,
    parameter int AP_BIT    = 10,
    parameter int BURST_LEN = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            cs_n,
    input  logic                            cke,
    input  logic                            ras_n,
    input  logic                            cas_n,
    input  logic                            we_n,
    input  logic [BA_W-1:0]                 ba,
    input  logic [ROW_W-1:0]                addr,
    output logic [NUM_BANKS-1:0]            bank_active,
    output logic [NUM_BANKS-1:0][ROW_W-1:0] open_row,
    output logic                            cmd_err
);

    cmd_t                  cmd;
    logic                  run;
    logic                  live;
    logic [BA_W-1:0]       cur_bank;
    logic                  last_edge;
    logic [NUM_BANKS-1:0]  pend;
    logic                  ap_busy;
    logic                  rw_ok;
    logic                  err_d;

    sdram_cmd_decode #(.ROW_W(ROW_W), .AP_BIT(AP_BIT)) u_dec (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .cke   (cke),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba    (ba),
        .addr  (addr),
        .cmd   (cmd),
        .run   (run)
    );

    assign ap_busy = live && pend[cur_bank];
    assign rw_ok   = is_rw(cmd.kind) && bank_active[cmd.bank] && !ap_busy;
    assign err_d   = ((cmd.kind == CMD_ACT) && bank_active[cmd.bank])
                   || (is_rw(cmd.kind) && !rw_ok);

    sdram_burst_sched #(.BURST_LEN(BURST_LEN)) u_sched (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .start      (rw_ok),
        .start_bank (cmd.bank),
        .live       (live),
        .cur_bank   (cur_bank),
        .last_edge  (last_edge)
    );

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic hit;
        assign hit = (cmd.bank == BA_W'(i));

        sdram_bank_slice #(.ROW_W(ROW_W)) u_slice (
            .clk      (clk),
            .rst      (rst),
            .act_set  (hit && (cmd.kind == CMD_ACT) && !bank_active[i]),
            .row_in   (addr),
            .pre_clr  (hit && (cmd.kind == CMD_PRE)),
            .ap_set   (hit && rw_ok && cmd.ap),
            .auto_end (last_edge && (cur_bank == BA_W'(i))),
            .active   (bank_active[i]),
            .row      (open_row[i]),
            .pend     (pend[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_err <= 1'b0;
        else     cmd_err <= err_d;
    end

endmodule

// File: rtl/sdram_bank_tracker_chk.sv
module sdram_bank_tracker_chk
    import sdram_bank_pkg::*;
#(
    parameter int ROW_W = 11
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            cs_n,
    input logic                            cke,
    input logic                            ras_n,
    input logic                            cas_n,
    input logic                            we_n,
    input logic [BA_W-1:0]                 ba,
    input logic [NUM_BANKS-1:0]            bank_active,
    input logic [NUM_BANKS-1:0][ROW_W-1:0] open_row,
    input logic                            cmd_err
);

    // R2: a deselected edge never produces an error
    a_r2_cs_quiet: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !cmd_err);

    // R12: an error pulse is always preceded by a selected edge
    a_r12_err_source: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> $past(!cs_n));

    // R3: a low clock enable freezes the following edge
    a_r3_suspend_hold: assert property (@(posedge clk) disable iff (rst)
        !cke |=> ##1 ($stable(bank_active) && !cmd_err));

    // R11: a code outside the four decoded commands leaves the flags alone
    a_r11_other_inert: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && ({ras_n, cas_n, we_n} inside {3'b000, 3'b001, 3'b110}))
        |=> !cmd_err);

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_chk
        // R4: a bank opens only after an activate addressed to it
        a_r4_open_cause: assert property (@(posedge clk) disable iff (rst)
            $rose(bank_active[i]) |->
            $past(!cs_n && !ras_n && cas_n && we_n && (ba == BA_W'(i))));

        // R5: the open row cannot move while the bank stays open
        a_r5_row_held: assert property (@(posedge clk) disable iff (rst)
            (bank_active[i] && $past(bank_active[i])) |-> $stable(open_row[i]));
    end

endmodule

bind sdram_bank_tracker sdram_bank_tracker_chk #(.ROW_W(ROW_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .cke         (cke),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .ba          (ba),
    .bank_active (bank_active),
    .open_row    (open_row),
    .cmd_err     (cmd_err)
);

// File: tb/sdram_bank_tracker_tb.sv
`timescale 1ns/1ps
module sdram_bank_tracker_tb;

    localparam int RW = 11;
    localparam int BL = 4;
    localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
                           C_WR = 3'b100, C_PRE = 3'b010;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, cke = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic [RW-1:0] addr = '0;
    logic [3:0] bank_active;
    logic [3:0][RW-1:0] open_row;
    logic cmd_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string req = "R1";

    always #2 clk = ~clk;

    sdram_bank_tracker #(.ROW_W(RW), .AP_BIT(10), .BURST_LEN(BL)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .cke(cke), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .bank_active(bank_active), .open_row(open_row), .cmd_err(cmd_err)
    );

    // behavioural reference
    bit          m_act [4];
    logic [RW-1:0] m_row [4];
    bit          m_pend [4];
    int          m_cnt, m_cur;
    bit          m_ckeq, m_err;

    always @(posedge clk) begin
        bit n_act [4];
        logic [RW-1:0] n_row [4];
        bit n_pend [4];
        int n_cnt, n_cur, b;
        bit e, busy;
        if (rst) begin
            for (int k = 0; k < 4; k++) begin
                m_act[k] = 0; m_row[k] = '0; m_pend[k] = 0;
            end
            m_cnt = 0; m_cur = 0; m_ckeq = 0; m_err = 0;
        end else begin
            n_act = m_act; n_row = m_row; n_pend = m_pend;
            n_cnt = m_cnt; n_cur = m_cur; e = 0;
            if (m_ckeq) begin
                b = ba;
                busy = (m_cnt > 0) && m_pend[m_cur];
                if (m_cnt > 0) n_cnt = m_cnt - 1;
                if (m_cnt == 1 && m_pend[m_cur]) begin
                    n_act[m_cur] = 0; n_pend[m_cur] = 0;
                end
                if (!cs_n) begin
                    case ({ras_n, cas_n, we_n})
                        C_ACT: if (m_act[b]) e = 1;
                               else begin n_act[b] = 1; n_row[b] = addr; end
                        C_RD, C_WR:
                            if (!m_act[b] || busy) e = 1;
                            else begin
                                n_cnt = BL; n_cur = b;
                                if (addr[10]) n_pend[b] = 1;
                            end
                        C_PRE: begin n_act[b] = 0; n_pend[b] = 0; end
                        default: ;
                    endcase
                end
            end
            m_act = n_act; m_row = n_row; m_pend = n_pend;
            m_cnt = n_cnt; m_cur = n_cur; m_err = e; m_ckeq = cke;
        end
    end

    task automatic compare();
        logic [3:0] exp_act;
        for (int k = 0; k < 4; k++) exp_act[k] = m_act[k];
        checks++;
        if (bank_active !== exp_act) begin
            failures++;
            $display("FAIL %s bank_active actual=%b expected=%b t=%0t", req, bank_active, exp_act, $time);
        end
        for (int k = 0; k < 4; k++) begin
            checks++;
            if (open_row[k] !== m_row[k]) begin
                failures++;
                $display("FAIL %s open_row[%0d] actual=%h expected=%h t=%0t", req, k, open_row[k], m_row[k], $time);
            end
        end
        checks++;
        if (cmd_err !== m_err) begin
            failures++;
            $display("FAIL %s R12 cmd_err actual=%b expected=%b t=%0t", req, cmd_err, m_err, $time);
        end
    endtask

    task automatic step(input logic [2:0] c, input int b, input int a,
                        input logic sel_n = 1'b0, input logic ck = 1'b1);
        @(negedge clk);
        if (!rst) compare();
        {ras_n, cas_n, we_n} = c;
        ba = b[1:0]; addr = a[RW-1:0]; cs_n = sel_n; cke = ck;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(C_NOP, 0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        req = "R1";
        checks++;
        if (bank_active !== 4'b0 || cmd_err !== 1'b0 || open_row !== '0) begin
            failures++;
            $display("FAIL R1 reset outputs actual=%b/%b/%h expected=0/0/0", bank_active, cmd_err, open_row);
        end
        rst = 1'b0;
        idle(2);

        req = "R4";
        step(C_ACT, 2, 'h155); step(C_ACT, 0, 'h7FF); step(C_ACT, 3, 'h001); idle(1);
        req = "R5";
        step(C_ACT, 2, 'h0AA); idle(1); step(C_ACT, 0, 'h123); idle(1);
        req = "R6";
        step(C_RD, 1, 0); idle(1); step(C_WR, 1, 'h400); idle(1);
        req = "R7";
        step(C_WR, 2, 'h000); idle(6);
        req = "R8";
        step(C_RD, 2, 'h400); idle(6);
        step(C_ACT, 2, 'h033); idle(1);
        req = "R3";
        step(C_NOP, 0, 0, 1'b0, 1'b0);
        step(C_ACT, 1, 'h010); idle(2);
        step(C_RD, 0, 'h400); idle(1);
        step(C_NOP, 0, 0, 1'b0, 1'b0); step(C_NOP, 0, 0, 1'b0, 1'b0);
        step(C_ACT, 1, 'h020); idle(6);
        step(C_ACT, 0, 'h123); idle(1);
        req = "R2";
        step(C_ACT, 1, 'h040, 1'b1); step(C_PRE, 0, 0, 1'b1);
        step(C_RD, 1, 0, 1'b1); step(C_ACT, 0, 'h050, 1'b1); idle(2);
        req = "R9";
        step(C_PRE, 1, 0); idle(1); step(C_PRE, 0, 0); idle(1);
        step(C_ACT, 0, 'h001); step(C_WR, 0, 'h400); idle(1);
        step(C_PRE, 0, 0); step(C_ACT, 0, 'h002); idle(6);
        req = "R10";
        step(C_RD, 2, 'h400); step(C_WR, 0, 0); idle(1); step(C_RD, 3, 'h400); idle(5);
        step(C_ACT, 2, 'h005); step(C_RD, 2, 'h000); idle(1);
        step(C_WR, 0, 'h400); idle(1); step(C_RD, 2, 0); idle(6);
        req = "R11";
        step(3'b000, 1, 'h7FF); step(3'b001, 2, 'h400); step(3'b110, 3, 'h400);
        step(3'b111, 2, 'h400); idle(2);
        req = "R12";
        step(C_ACT, 3, 'h100); step(C_ACT, 3, 'h101); idle(3);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule